// File: doc/BRIEF.md
# Idle Column Rate-Matching Buffer

This block sits on the receive side of a four-lane, byte-striped link after the lanes have been aligned to one another. Each write clock it accepts one column: a byte from every lane, each with its own control flag. It delivers the same columns in a second clock domain that runs at nominally the same frequency. The two clocks may drift apart a little, so the buffer absorbs the difference.

It never edits single bytes. When the write side sees the buffer getting full, it drops an incoming column whose four lanes all carry the R idle control character. When the read side sees the buffer getting empty, it sends an R column twice. Data columns, end-of-packet columns and the A and K idle columns always pass through unchanged and in order. Rate changes are limited to one per window of columns, and they only happen after the link reports that it is aligned.

Top module: `ebuf_idle_rm`

## Requirements
- R1: A column may be dropped or repeated only if all four control flags are 1 and all four bytes equal 8'h1C, the R idle code. Lane i uses data bits [8i+7:8i] and control bit i. Every other column, including one that has R in only three lanes, comes out once and in input order.
- R2: An eligible column that arrives while the write-side fill is at or above 12 (of 16) is discarded, and delCount goes up by one.
- R3: When the head of the buffer is an eligible column and the read-side fill is at or below 4, that column is output twice in a row and insCount goes up by one. No column is inserted anywhere else, so an A column (all lanes control with 8'h7C) is always followed directly by the K column that came after it.
- R4: While the column was written with wrAligned low, it is never dropped or repeated.
- R5: Two deletes are at least 16 write cycles apart, and two inserts are at least 16 read cycles apart.
- R6: After reset, rdValid is low and all four counters are zero. Output starts only after the fill has reached 8 columns.
- R7: A column that arrives while the buffer is full and cannot be dropped is lost and counted in ovfCount. A read cycle that finds the buffer empty after output has started gives rdValid low and is counted in unfCount. Under normal drift, with idle gaps, both counters stay at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-domain clock |
| wrRstN | input | 1 | Write-domain active-low asynchronous reset |
| wrCtl | input | 4 | Control flag per lane of the incoming column |
| wrData | input | 32 | Incoming column bytes, lane 0 in the low byte |
| wrAligned | input | 1 | High once the lanes are synchronized and deskewed |
| rdClk | input | 1 | Read-domain clock |
| rdRstN | input | 1 | Read-domain active-low asynchronous reset |
| rdValid | output | 1 | Output column is valid this read cycle |
| rdCtl | output | 4 | Control flags of the output column |
| rdData | output | 32 | Bytes of the output column |
| insCount | output | 16 | Inserted R columns (read domain) |
| delCount | output | 16 | Deleted R columns (write domain) |
| ovfCount | output | 16 | Columns lost to overflow (write domain) |
| unfCount | output | 16 | Empty read cycles after start (read domain) |

## Verification
The assertions assume that the two clocks differ by only a few percent. They also assume that R columns appear in the incoming stream often enough for the watermarks to keep the true fill away from empty and full, so no column has to be given up. The stimulus repeats a 15-column pattern: data columns, a column with R bytes in three lanes only, an end-of-packet column, and then one A, one K and four R columns. The read clock is set 4% slower, then 4% faster, then about 2% slower while alignment is low, so the fill moves toward each watermark without crossing the hard limits.

// File: rtl/ebuf_pkg.sv
package ebuf_pkg;
  localparam int LANES  = 4;
  localparam int BYTE_W = 8;
  localparam int COL_W  = LANES * BYTE_W;
  localparam logic [BYTE_W-1:0] IDLE_R = 8'h1C;

  // One striped column as stored in the buffer, tagged with link alignment.
  typedef struct packed {
    logic              aligned;
    logic [LANES-1:0]  ctl;
    logic [COL_W-1:0]  data;
  } col_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic push;  // write domain: store the incoming column
    logic pop;   // read domain: advance past the head column
    logic show;  // read domain: load the head column into the output
  } strobe_t;

  function automatic logic isIdleCol(input col_t c);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < LANES; i++)
      ok = ok & c.ctl[i] & (c.data[i*BYTE_W +: BYTE_W] == IDLE_R);
    return ok;
  endfunction
endpackage

// File: rtl/ebuf_sync.sv
module ebuf_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/ebuf_dp.sv
module ebuf_dp import ebuf_pkg::*; #(
  parameter int DEPTH = 16,  // power of two
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic             wrClk,
  input  logic             wrRstN,
  input  logic             rdClk,
  input  logic             rdRstN,
  input  col_t             inCol,
  input  strobe_t          stb,
  output logic [PW-1:0]    wrFill,
  output logic [PW-1:0]    rdFill,
  output col_t             headCol,
  output logic             outValid,
  output logic [LANES-1:0] outCtl,
  output logic [COL_W-1:0] outData
);
  function automatic logic [PW-1:0] toGray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] fromGray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  col_t mem [DEPTH];

  logic [PW-1:0] wrBin, wrGray, wrBinNext;
  logic [PW-1:0] rdBin, rdGray, rdBinNext;
  logic [PW-1:0] rdGraySync, wrGraySync;

  assign wrBinNext = wrBin + 1'b1;
  assign rdBinNext = rdBin + 1'b1;

  // Write domain
  always_ff @(posedge wrClk) begin
    if (stb.push) mem[wrBin[AW-1:0]] <= inCol;
  end

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      wrBin  <= '0;
      wrGray <= '0;
    end else if (stb.push) begin
      wrBin  <= wrBinNext;
      wrGray <= toGray(wrBinNext);
    end
  end

  ebuf_sync #(.W(PW)) uRdToWr (.clk(wrClk), .rstN(wrRstN), .d(rdGray), .q(rdGraySync));
  assign wrFill = wrBin - fromGray(rdGraySync);

  // Read domain
  ebuf_sync #(.W(PW)) uWrToRd (.clk(rdClk), .rstN(rdRstN), .d(wrGray), .q(wrGraySync));
  assign rdFill  = fromGray(wrGraySync) - rdBin;
  assign headCol = mem[rdBin[AW-1:0]];

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      rdBin    <= '0;
      rdGray   <= '0;
      outValid <= 1'b0;
      outCtl   <= '0;
      outData  <= '0;
    end else begin
      outValid <= stb.show;
      if (stb.show) begin
        outCtl  <= headCol.ctl;
        outData <= headCol.data;
      end
      if (stb.pop) begin
        rdBin  <= rdBinNext;
        rdGray <= toGray(rdBinNext);
      end
    end
  end

  // Assertions
  a_r7_no_push_full: assert property (@(posedge wrClk) disable iff (!wrRstN)
    stb.push |-> (wrFill < PW'(DEPTH)));

  a_r1_only_r_dropped: assert property (@(posedge wrClk) disable iff (!wrRstN)
    (!stb.push && (wrFill < PW'(DEPTH))) |-> isIdleCol(inCol));

  a_r4_drop_aligned: assert property (@(posedge wrClk) disable iff (!wrRstN)
    (!stb.push && (wrFill < PW'(DEPTH))) |-> inCol.aligned);

  a_r3_insert_repeats: assert property (@(posedge rdClk) disable iff (!rdRstN)
    ($past(stb.show && !stb.pop, 2) && outValid) |-> ({outCtl, outData} == $past({outCtl, outData})));
endmodule

// File: rtl/ebuf_ctrl.sv
module ebuf_ctrl import ebuf_pkg::*; #(
  parameter int DEPTH      = 16,
  parameter int HIGH_MARK  = 12,
  parameter int LOW_MARK   = 4,
  parameter int PRIME_MARK = 8,
  parameter int WINDOW     = 16,
  parameter int CNT_W      = 16,
  localparam int PW = $clog2(DEPTH) + 1,
  localparam int CW = $clog2(WINDOW + 1)
) (
  input  logic             wrClk,
  input  logic             wrRstN,
  input  logic             rdClk,
  input  logic             rdRstN,
  input  col_t             inCol,
  input  col_t             headCol,
  input  logic [PW-1:0]    wrFill,
  input  logic [PW-1:0]    rdFill,
  output strobe_t          stb,
  output logic [CNT_W-1:0] insCount,
  output logic [CNT_W-1:0] delCount,
  output logic [CNT_W-1:0] ovfCount,
  output logic [CNT_W-1:0] unfCount
);
  // Write side: delete decision
  logic [CW-1:0] delCool;
  logic delNow, wrFull, ovfNow;

  assign wrFull = (wrFill == PW'(DEPTH));
  assign delNow = inCol.aligned && isIdleCol(inCol) &&
                  (wrFill >= PW'(HIGH_MARK)) && (delCool == '0);
  assign ovfNow = !delNow && wrFull;

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      delCool  <= '0;
      delCount <= '0;
      ovfCount <= '0;
    end else begin
      if (delNow)              delCool <= CW'(WINDOW - 1);
      else if (delCool != '0)  delCool <= delCool - 1'b1;
      if (delNow) delCount <= delCount + 1'b1;
      if (ovfNow) ovfCount <= ovfCount + 1'b1;
    end
  end

  // Read side: priming, insert decision
  logic [CW-1:0] insCool;
  logic primed, rdEmpty, showNow, insNow, unfNow;

  assign rdEmpty = (rdFill == '0);
  assign showNow = primed && !rdEmpty;
  assign insNow  = showNow && headCol.aligned && isIdleCol(headCol) &&
                   (rdFill <= PW'(LOW_MARK)) && (insCool == '0);
  assign unfNow  = primed && rdEmpty;

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      primed   <= 1'b0;
      insCool  <= '0;
      insCount <= '0;
      unfCount <= '0;
    end else begin
      if (rdFill >= PW'(PRIME_MARK)) primed <= 1'b1;
      if (insNow)              insCool <= CW'(WINDOW - 1);
      else if (insCool != '0)  insCool <= insCool - 1'b1;
      if (insNow) insCount <= insCount + 1'b1;
      if (unfNow) unfCount <= unfCount + 1'b1;
    end
  end

  always_comb begin
    stb.push = !delNow && !wrFull;
    stb.show = showNow;
    stb.pop  = showNow && !insNow;
  end

  // Independent spacing counters for the checks below
  logic [CW-1:0] sinceDel, sinceIns;

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN)                        sinceDel <= CW'(WINDOW);
    else if (delNow)                    sinceDel <= '0;
    else if (sinceDel != CW'(WINDOW))   sinceDel <= sinceDel + 1'b1;
  end

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN)                        sinceIns <= CW'(WINDOW);
    else if (insNow)                    sinceIns <= '0;
    else if (sinceIns != CW'(WINDOW))   sinceIns <= sinceIns + 1'b1;
  end

  a_r5_del_spacing: assert property (@(posedge wrClk) disable iff (!wrRstN)
    delNow |-> (sinceDel >= CW'(WINDOW - 1)));

  a_r5_ins_spacing: assert property (@(posedge rdClk) disable iff (!rdRstN)
    insNow |-> (sinceIns >= CW'(WINDOW - 1)));
endmodule

// File: rtl/ebuf_idle_rm.sv
module ebuf_idle_rm import ebuf_pkg::*; #(
  parameter int DEPTH      = 16,
  parameter int HIGH_MARK  = 12,
  parameter int LOW_MARK   = 4,
  parameter int PRIME_MARK = 8,
  parameter int WINDOW     = 16,
  parameter int CNT_W      = 16
) (
  input  logic             wrClk,
  input  logic             wrRstN,
  input  logic [LANES-1:0] wrCtl,
  input  logic [COL_W-1:0] wrData,
  input  logic             wrAligned,
  input  logic             rdClk,
  input  logic             rdRstN,
  output logic             rdValid,
  output logic [LANES-1:0] rdCtl,
  output logic [COL_W-1:0] rdData,
  output logic [CNT_W-1:0] insCount,
  output logic [CNT_W-1:0] delCount,
  output logic [CNT_W-1:0] ovfCount,
  output logic [CNT_W-1:0] unfCount
);
  localparam int PW = $clog2(DEPTH) + 1;

  col_t          inCol, headCol;
  strobe_t       stb;
  logic [PW-1:0] wrFill, rdFill;

  assign inCol = '{aligned: wrAligned, ctl: wrCtl, data: wrData};

  ebuf_ctrl #(
    .DEPTH(DEPTH), .HIGH_MARK(HIGH_MARK), .LOW_MARK(LOW_MARK),
    .PRIME_MARK(PRIME_MARK), .WINDOW(WINDOW), .CNT_W(CNT_W)
  ) uCtrl (
    .wrClk(wrClk), .wrRstN(wrRstN), .rdClk(rdClk), .rdRstN(rdRstN),
    .inCol(inCol), .headCol(headCol), .wrFill(wrFill), .rdFill(rdFill),
    .stb(stb), .insCount(insCount), .delCount(delCount),
    .ovfCount(ovfCount), .unfCount(unfCount)
  );

  ebuf_dp #(.DEPTH(DEPTH)) uDp (
    .wrClk(wrClk), .wrRstN(wrRstN), .rdClk(rdClk), .rdRstN(rdRstN),
    .inCol(inCol), .stb(stb), .wrFill(wrFill), .rdFill(rdFill),
    .headCol(headCol), .outValid(rdValid), .outCtl(rdCtl), .outData(rdData)
  );
endmodule

// File: tb/ebuf_idle_rm_test.sv
`timescale 1ns/1ps
module ebuf_idle_rm_test;
  localparam logic [35:0] COL_R = {4'hF, 32'h1C1C1C1C};
  localparam logic [35:0] COL_A = {4'hF, 32'h7C7C7C7C};
  localparam logic [35:0] COL_K = {4'hF, 32'hBCBCBCBC};

  logic wrClk = 1'b0, rdClk = 1'b0, wrRstN = 1'b0, rdRstN = 1'b0;
  logic [3:0]  wrCtl = 4'hF;
  logic [31:0] wrData = 32'h1C1C1C1C;
  logic        wrAligned = 1'b0;
  logic        rdValid;
  logic [3:0]  rdCtl;
  logic [31:0] rdData;
  logic [15:0] insCount, delCount, ovfCount, unfCount;

  real rdHalf = 2.5;
  always #2.5 wrClk = ~wrClk;
  always #(rdHalf) rdClk = ~rdClk;

  ebuf_idle_rm uut (
    .wrClk(wrClk), .wrRstN(wrRstN), .wrCtl(wrCtl), .wrData(wrData),
    .wrAligned(wrAligned), .rdClk(rdClk), .rdRstN(rdRstN),
    .rdValid(rdValid), .rdCtl(rdCtl), .rdData(rdData),
    .insCount(insCount), .delCount(delCount),
    .ovfCount(ovfCount), .unfCount(unfCount)
  );

  int vectors = 0, miscompares = 0;
  int wrCols = 0;
  bit done = 1'b0;
  logic [35:0] expQ[$];
  logic [7:0] seq = 8'h00;

  task automatic check(input bit ok, input string tag,
                       input logic [35:0] act, input logic [35:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic sendCol(input logic [35:0] c);
    @(negedge wrClk);
    {wrCtl, wrData} = c;
    wrCols++;
    if (c != COL_R) expQ.push_back(c);
  endtask

  // 15 columns: 7 data, a column with R in three lanes only, an end column, A, K, 4 x R
  task automatic sendPacket();
    for (int i = 0; i < 7; i++) begin
      sendCol({4'h0, seq, seq ^ 8'h5A, seq + 8'd3, 8'(i)});
      seq = seq + 1'b1;
    end
    sendCol({4'b0111, 32'h1C1C1C1C});
    sendCol({4'hF, 32'h1C1C1CFD});
    sendCol(COL_A);
    sendCol(COL_K);
    for (int i = 0; i < 4; i++) sendCol(COL_R);
  endtask

  // Read-side monitor: scoreboard, A->K adjacency, insert spacing, start point
  bit prevA = 1'b0, seenValid = 1'b0, haveIns = 1'b0;
  int rdCyc = 0, lastInsCyc = 0;
  logic [15:0] lastIns = '0;

  always @(negedge rdClk) begin
    if (rdRstN && !done) begin
      rdCyc++;
      if (insCount != lastIns) begin
        if (haveIns)
          check(rdCyc - lastInsCyc >= 16, "R5 insert spacing",
                36'(rdCyc - lastInsCyc), 36'd16);
        haveIns = 1'b1;
        lastInsCyc = rdCyc;
        lastIns = insCount;
      end
      if (rdValid) begin
        if (!seenValid) begin
          seenValid = 1'b1;
          check(wrCols >= 8, "R6 output starts after fill of 8", 36'(wrCols), 36'd8);
        end
        if (prevA) check({rdCtl, rdData} == COL_K, "R3 A followed by K", {rdCtl, rdData}, COL_K);
        prevA = ({rdCtl, rdData} == COL_A);
        if ({rdCtl, rdData} != COL_R) begin
          if (expQ.size() == 0) check(1'b0, "R1 unexpected column", {rdCtl, rdData}, '0);
          else begin
            logic [35:0] exp;
            exp = expQ.pop_front();
            check({rdCtl, rdData} == exp, "R1 column order", {rdCtl, rdData}, exp);
          end
        end
      end
    end
  end

  // Write-side monitor: delete spacing
  bit haveDel = 1'b0;
  int wrCyc = 0, lastDelCyc = 0;
  logic [15:0] lastDel = '0;

  always @(negedge wrClk) begin
    if (wrRstN && !done) begin
      wrCyc++;
      if (delCount != lastDel) begin
        if (haveDel)
          check(wrCyc - lastDelCyc >= 16, "R5 delete spacing",
                36'(wrCyc - lastDelCyc), 36'd16);
        haveDel = 1'b1;
        lastDelCyc = wrCyc;
        lastDel = delCount;
      end
    end
  end

  initial begin
    logic [15:0] baseIns, baseDel;
    repeat (4) @(negedge wrClk);
    check(rdValid == 1'b0, "R6 reset rdValid", 36'(rdValid), 36'd0);
    check(insCount == 0 && delCount == 0, "R6 reset ins/del", {4'h0, insCount, delCount}, '0);
    check(ovfCount == 0 && unfCount == 0, "R6 reset ovf/unf", {4'h0, ovfCount, unfCount}, '0);
    wrRstN = 1'b1;
    rdRstN = 1'b1;
    wrAligned = 1'b1;

    // Phase 1: slower reader, deletes expected
    rdHalf = 2.6;
    repeat (200) sendPacket();
    check(delCount > 0, "R2 deletes when filling", 36'(delCount), 36'd1);
    check(insCount == 0, "R3 no insert while fill is high", 36'(insCount), 36'd0);
    check(ovfCount == 0, "R7 no overflow", 36'(ovfCount), 36'd0);

    // Phase 2: faster reader, inserts expected
    rdHalf = 2.4;
    repeat (260) sendPacket();
    check(insCount > 0, "R3 inserts when draining", 36'(insCount), 36'd1);
    check(unfCount == 0, "R7 no underflow", 36'(unfCount), 36'd0);

    // Phase 3: alignment low, fill drifts upward, no changes allowed
    rdHalf = 2.55;
    wrAligned = 1'b0;
    repeat (4) sendPacket();
    @(negedge rdClk);
    baseIns = insCount;
    baseDel = delCount;
    repeat (16) sendPacket();
    @(negedge rdClk);
    check(insCount == baseIns, "R4 no insert while unaligned", 36'(insCount), 36'(baseIns));
    check(delCount == baseDel, "R4 no delete while unaligned", 36'(delCount), 36'(baseDel));

    // Phase 4: matched clocks, then flush with idles
    rdHalf = 2.5;
    wrAligned = 1'b1;
    repeat (30) sendPacket();
    repeat (40) sendCol(COL_R);
    repeat (100) @(negedge rdClk);
    check(expQ.size() == 0, "R1 all columns delivered", 36'(expQ.size()), 36'd0);
    check(ovfCount == 0, "R7 final overflow count", 36'(ovfCount), 36'd0);
    check(unfCount == 0, "R7 final underflow count", 36'(unfCount), 36'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #900us;
    if (!done) begin
      done = 1'b1;
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule